// File: doc/BRIEF.md
# Half-bridge interlock and dead-time controller

This block sits between the PWM logic and the gate drivers of one half-bridge leg. It takes a high-side and a low-side command and produces two gate enables, one for each switch. Each enable follows its own command with no inversion. The block never lets both switches conduct at once. Both commands and both under-voltage flags are first brought into the clock domain through a synchronizer chain.

Before either enable turns on, the opposite enable must have been off for a programmable number of clock cycles, the dead time. Each side also has its own under-voltage flag. While that flag is raised it forces the side's enable off. When the flag clears, the side restarts its dead-time wait before turning on. When both commands are high together, both enables are forced off.

`DT_CYCLES` sets the dead time in cycles. At a 200 MHz clock the default of 80 gives 400 ns. Values of 66 to 116 cover 330 ns to 580 ns.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: An enable is on only while its own command is high; with only one command high and no flag raised, that side's enable is on in the steady state and the other is off.
- R2: After a command falls, its enable goes low on the third rising clock edge after the change.
- R3: With the opposite enable already off, a command rise turns its enable on at the edge DT_CYCLES+3 after the change, not earlier.
- R4: While both commands are high, both enables are off; an enable that was on goes low on the third edge after the second command rises.
- R5: The two enables are never high in the same cycle.
- R6: An enable turns on only after the opposite enable has been low for at least DT_CYCLES consecutive cycles; in a simultaneous handoff the new side turns on at edge DT_CYCLES+4 after the change.
- R7: A command pulse shorter than DT_CYCLES cycles never raises its enable.
- R8: A raised under-voltage flag (active high) forces that side's enable low by the third edge after the change, and keeps it low whatever the command does.
- R9: When a flag clears while its command is high, the enable turns on at edge DT_CYCLES+3 after the clear.
- R10: Synchronous active-high reset drives both enables low. After release with a command held high, the enable turns on at edge DT_CYCLES+3, not earlier.
- R11: A flag affects only its own side; the other side's enable is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd | input | 1 | Low-side command, active high |
| hi_uv | input | 1 | High-side under-voltage flag, high = supply too low |
| lo_uv | input | 1 | Low-side under-voltage flag, high = supply too low |
| hi_gate | output | 1 | High-side gate enable, registered |
| lo_gate | output | 1 | Low-side gate enable, registered |

## Verification
The properties assume that the commands and flags reach the channel logic only through the synchronizer. They also assume that the dead-time counter is the only path by which an enable rises. The latency properties count edges on the synchronized copies, not on the pins. The bench changes every input on the falling clock edge and holds each table vector for longer than one dead time, so each steady state settles before it is checked. Directed cases then place command changes at exact edge counts to probe the latency bounds, handoff, short pulses and flag release.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned SIDES   = 2;
  localparam int unsigned SIDE_HI = 0;
  localparam int unsigned SIDE_LO = 1;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_dt_channel.sv
module hb_dt_channel #(
  parameter int unsigned DT_CYCLES = 80,
  parameter int unsigned CNT_W     = $clog2(DT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_own,
  input  logic cmd_opp,
  input  logic uv_own,
  input  logic out_opp,
  output logic out_own
);
  localparam logic [CNT_W-1:0] DT_LIM = CNT_W'(DT_CYCLES);

  logic             want;
  logic [CNT_W-1:0] cnt;

  // the side may conduct only when it alone is commanded and its supply is good
  assign want = cmd_own & ~cmd_opp & ~uv_own;

  // the wait restarts whenever the request drops or the other side conducts
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (!want || out_opp)  cnt <= '0;
    else if (cnt != DT_LIM)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) out_own <= 1'b0;
    else     out_own <= want & ~out_opp & (cnt == DT_LIM);
  end

  AST_CMD_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !cmd_own |=> !out_own);                                        // R2
  AST_BOTH_CMD_OFF: assert property (@(posedge clk) disable iff (rst)
    cmd_opp |=> !out_own);                                         // R4
  AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    uv_own |=> !out_own);                                          // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= DT_LIM);                                                // R3
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int unsigned DT_CYCLES   = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic hi_uv,
  input  logic lo_uv,
  output logic hi_gate,
  output logic lo_gate
);
  import hb_pkg::*;

  localparam int unsigned CNT_W = $clog2(DT_CYCLES + 1);
  localparam logic [CNT_W-1:0] DT_LIM = CNT_W'(DT_CYCLES);

  logic [2*SIDES-1:0] raw_in;
  logic [2*SIDES-1:0] sync_in;
  logic [SIDES-1:0]   cmd_s;
  logic [SIDES-1:0]   uv_s;
  logic [SIDES-1:0]   gate;

  assign raw_in = {lo_uv, hi_uv, lo_cmd, hi_cmd};

  hb_sync #(.WIDTH(2*SIDES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign cmd_s = sync_in[SIDES-1:0];
  assign uv_s  = sync_in[2*SIDES-1:SIDES];

  for (genvar gi = 0; gi < SIDES; gi++) begin : g_side
    hb_dt_channel #(.DT_CYCLES(DT_CYCLES), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cmd_own (cmd_s[gi]),
      .cmd_opp (cmd_s[SIDES-1-gi]),
      .uv_own  (uv_s[gi]),
      .out_opp (gate[SIDES-1-gi]),
      .out_own (gate[gi])
    );

    // run length of this side's enable being low, for the gap property
    logic [CNT_W-1:0] off_run;
    always_ff @(posedge clk) begin
      if (rst)                  off_run <= '0;
      else if (gate[gi])        off_run <= '0;
      else if (off_run != DT_LIM) off_run <= off_run + 1'b1;
    end
  end

  assign hi_gate = gate[SIDE_HI];
  assign lo_gate = gate[SIDE_LO];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hi_gate && lo_gate));                                        // R5
  AST_HI_DT_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_gate) |-> (g_side[SIDE_LO].off_run == DT_LIM));       // R6
  AST_LO_DT_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_gate) |-> (g_side[SIDE_HI].off_run == DT_LIM));       // R6
  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (!hi_gate && !lo_gate));                               // R10
endmodule

// File: tb/hb_deadtime_ctrl_test.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_test;
  localparam int DT   = 80;
  localparam int HOLD = DT + 12;
  localparam int NVEC = 12;

  // {hi_cmd, lo_cmd, hi_uv, lo_uv, exp_hi, exp_lo}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1000_10, 6'b0000_00, 6'b0100_01, 6'b1100_00,
    6'b1000_10, 6'b1010_00, 6'b1000_10, 6'b0101_00,
    6'b0110_01, 6'b1001_10, 6'b1111_00, 6'b0011_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_cmd = 1'b0, lo_cmd = 1'b0, hi_uv = 1'b0, lo_uv = 1'b0;
  logic hi_gate, lo_gate;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl #(.DT_CYCLES(DT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .hi_uv(hi_uv), .lo_uv(lo_uv), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // continuous monitors: overlap (R5) and dead-time gap (R6)
  int  hi_off = 0, lo_off = 0;
  logic prev_hi = 1'b0, prev_lo = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      hi_off <= 0; lo_off <= 0; prev_hi <= 1'b0; prev_lo <= 1'b0;
    end else begin
      if (hi_gate && lo_gate) begin
        n_fail++;
        $display("FAIL R5: both enables high got 11 expected not 11 at %0t", $time);
      end
      if (hi_gate && !prev_hi) begin
        n_checks++;
        if (lo_off < DT) begin
          n_fail++;
          $display("FAIL R6: low-side off %0d cycles expected >= %0d", lo_off, DT);
        end
      end
      if (lo_gate && !prev_lo) begin
        n_checks++;
        if (hi_off < DT) begin
          n_fail++;
          $display("FAIL R6: high-side off %0d cycles expected >= %0d", hi_off, DT);
        end
      end
      hi_off  <= hi_gate ? 0 : hi_off + 1;
      lo_off  <= lo_gate ? 0 : lo_off + 1;
      prev_hi <= hi_gate;
      prev_lo <= lo_gate;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    tick(4);
    check("R10 reset hi", hi_gate, 1'b0);
    check("R10 reset lo", lo_gate, 1'b0);
    rst = 1'b0;

    // steady-state table: R1, R4, R8, R11
    for (int i = 0; i < NVEC; i++) begin
      {hi_cmd, lo_cmd, hi_uv, lo_uv} = VEC[i][5:2];
      tick(HOLD);
      check($sformatf("R1/R4/R8/R11 vec%0d hi", i), hi_gate, VEC[i][1]);
      check($sformatf("R1/R4/R8/R11 vec%0d lo", i), lo_gate, VEC[i][0]);
    end

    // R10: reset with command held high, then release timing
    {hi_cmd, lo_cmd, hi_uv, lo_uv} = 4'b1000;
    tick(HOLD);
    rst = 1'b1;
    tick(3);
    check("R10 reset forces off", hi_gate, 1'b0);
    rst = 1'b0;
    tick(DT + 2);
    check("R10 no early on", hi_gate, 1'b0);
    tick(1);
    check("R10 on after dead time", hi_gate, 1'b1);

    // R2: fall latency
    hi_cmd = 1'b0;
    tick(2);
    check("R2 still on at edge 2", hi_gate, 1'b1);
    tick(1);
    check("R2 off at edge 3", hi_gate, 1'b0);

    // R3: rise latency
    tick(10);
    hi_cmd = 1'b1;
    tick(DT + 2);
    check("R3 off at edge DT+2", hi_gate, 1'b0);
    tick(1);
    check("R3 on at edge DT+3", hi_gate, 1'b1);

    // R6: simultaneous handoff high -> low
    hi_cmd = 1'b0; lo_cmd = 1'b1;
    tick(DT + 3);
    check("R6 handoff lo off at DT+3", lo_gate, 1'b0);
    tick(1);
    check("R6 handoff lo on at DT+4", lo_gate, 1'b1);

    // R4: both high forces off, then remaining side waits
    hi_cmd = 1'b1;
    tick(2);
    check("R4 lo on at edge 2", lo_gate, 1'b1);
    tick(1);
    check("R4 lo off at edge 3", lo_gate, 1'b0);
    check("R4 hi off while both high", hi_gate, 1'b0);
    tick(20);
    lo_cmd = 1'b0;
    tick(DT + 2);
    check("R4 hi waits dead time", hi_gate, 1'b0);
    tick(1);
    check("R4 hi on after dead time", hi_gate, 1'b1);

    // R7: short pulse is swallowed
    hi_cmd = 1'b0;
    tick(10);
    begin
      logic seen;
      seen = 1'b0;
      hi_cmd = 1'b1;
      for (int k = 0; k < DT / 2; k++) begin
        tick(1);
        seen |= hi_gate;
      end
      hi_cmd = 1'b0;
      for (int k = 0; k < DT + 10; k++) begin
        tick(1);
        seen |= hi_gate;
      end
      check("R7 short pulse no output", seen, 1'b0);
    end

    // R8 / R9: flag forces off, release waits dead time
    hi_cmd = 1'b1;
    tick(DT + 5);
    check("R8 precondition hi on", hi_gate, 1'b1);
    hi_uv = 1'b1;
    tick(2);
    check("R8 on at edge 2", hi_gate, 1'b1);
    tick(1);
    check("R8 off at edge 3", hi_gate, 1'b0);
    tick(20);
    check("R8 held off", hi_gate, 1'b0);
    hi_uv = 1'b0;
    tick(DT + 2);
    check("R9 off at edge DT+2", hi_gate, 1'b0);
    tick(1);
    check("R9 on at edge DT+3", hi_gate, 1'b1);

    // R11: other side's flag leaves this side alone
    lo_uv = 1'b1;
    tick(10);
    check("R11 hi unaffected by lo flag", hi_gate, 1'b1);
    lo_uv = 1'b0;
    tick(5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule